// File: doc/BRIEF.md
# Key-Sequence Windowed Watchdog

This block is a watchdog timer for a processor subsystem. Once it is enabled, an internal counter runs toward the end of a selectable period. Software keeps the system alive by writing a two-byte key to the service register: first the arm byte 0x55, then the fire byte 0xAA. Only the completed pair restarts the count. If the count reaches the end of the period, or software writes anything that does not fit the key protocol, the block raises a reset request that lasts one clock cycle.

An optional windowed mode guards against runaway code that services the watchdog too often. In this mode a key byte is only accepted during the last quarter of the period, and a key byte written earlier is treated as a fault. The period is 2^(BASE_LOG + 2*sel) clock cycles. BASE_LOG defaults to 10, and a select value of zero leaves the watchdog idle.

Top module: `keyseq_watchdog`

## Requirements
- R1: A write of 0xAA that follows an accepted 0x55 restarts the count. After the 0xAA write edge e, no request is raised before edge e+T, where T is the current period.
- R2: Idle cycles between the 0x55 and the 0xAA writes, with svc_wr low, do not break the key sequence.
- R3: A service write whose data is neither 0x55 nor 0xAA raises rst_req in the cycle right after its write edge.
- R4: rst_req is low out of reset. Without servicing, rst_req is high for exactly one cycle, just after edge r+T, where r is the edge after which the count is zero.
- R5: T = 2^(BASE_LOG + 2*period_sel). When period_sel is 0 or wd_en is low, the watchdog is idle: the count stays at zero, writes are ignored and no request is raised.
- R6: With window_en high, a key byte is accepted when the count is at least T - T/4 at its write edge. The count after edge r+j is j.
- R7: With window_en high, a key byte written while the count is below T - T/4 raises rst_req in the next cycle.
- R8: A write of 0xAA that has no accepted 0x55 before it raises rst_req in the next cycle.
- R9: A second 0x55 written while already armed keeps the block armed, so a following 0xAA still completes the service.
- R10: A reset request clears the count to zero and drops the armed state. The next timeout comes T cycles after the request edge, and a lone 0xAA written after a fault is a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wd_en | input | 1 | Watchdog enable |
| period_sel | input | 3 | Period select, 0 = idle |
| window_en | input | 1 | Windowed service mode |
| svc_wr | input | 1 | Service register write strobe |
| svc_data | input | 8 | Service register write data |
| rst_req | output | 1 | One-cycle reset request |

## Verification
Every result of this block comes out of one register stage. A fault caused by a write shows on rst_req just after the write edge itself. A timeout shows just after edge r+T, counted from the edge that zeroed the count. The bench keeps a free-running edge counter. Before each write it pushes the expected pulse edge into a queue, and a monitor compares each pulse against that queue at the falling edge following the edge in question. Any pulse that is not expected, any pulse that is missing, or a pulse two cycles wide is reported against the requirement under test. This makes window boundaries such as count 47 against count 48 exact to the cycle.

// File: rtl/keyseq_wdg_pkg.sv
package keyseq_wdg_pkg;
  localparam int SEL_W = 3;
  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;

  typedef enum logic [1:0] {WR_NONE, WR_ARM, WR_FIRE, WR_ILLEGAL} wr_kind_e;

  // log2 of the period for a given select value
  function automatic int unsigned span_log2(input int unsigned base_log,
                                            input logic [SEL_W-1:0] sel);
    int unsigned s;
    s = {{(32-SEL_W){1'b0}}, sel};
    return base_log + (s << 1);
  endfunction

  // first count value that lies in the service window (last quarter)
  function automatic logic [31:0] window_start(input logic [31:0] len);
    return len - (len >> 2);
  endfunction

  function automatic wr_kind_e classify(input logic [7:0] d);
    case (d)
      KEY_ARM:  return WR_ARM;
      KEY_FIRE: return WR_FIRE;
      default:  return WR_ILLEGAL;
    endcase
  endfunction
endpackage

// File: rtl/keyseq_wdg_counter.sv
module keyseq_wdg_counter #(
  parameter int BASE_LOG = 10,
  parameter int CW       = 25
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              active,
  input  logic                              restart,
  input  logic [keyseq_wdg_pkg::SEL_W-1:0]  sel,
  output logic [CW-1:0]                     cnt,
  output logic                              at_end,
  output logic                              in_window
);
  logic [31:0] len32;
  logic [CW-1:0] len;
  logic [CW-1:0] win_lo;

  assign len32     = 32'd1 << keyseq_wdg_pkg::span_log2(BASE_LOG, sel);
  assign len       = len32[CW-1:0];
  assign win_lo    = keyseq_wdg_pkg::window_start(len32)[CW-1:0];
  assign at_end    = active && (cnt >= len - CW'(1));
  assign in_window = cnt >= win_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (restart || !active) cnt <= '0;
    else if (!at_end)           cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/keyseq_wdg_keytrack.sv
module keyseq_wdg_keytrack (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       flush,
  input  logic       svc_wr,
  input  logic [7:0] svc_data,
  input  logic       win_ok,
  output logic       armed,
  output logic       svc_done,
  output logic       bad_value,
  output logic       bad_order,
  output logic       early_key
);
  import keyseq_wdg_pkg::*;

  wr_kind_e kind;
  logic     is_key;

  assign kind      = (svc_wr && active) ? classify(svc_data) : WR_NONE;
  assign is_key    = (kind == WR_ARM) || (kind == WR_FIRE);
  assign early_key = is_key && !win_ok;
  assign bad_value = (kind == WR_ILLEGAL);
  assign bad_order = (kind == WR_FIRE) && !armed;
  assign svc_done  = (kind == WR_FIRE) && armed && win_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                armed <= 1'b0;
    else if (flush || !active) armed <= 1'b0;
    else if (kind == WR_ARM)   armed <= 1'b1;
    else if (svc_done)         armed <= 1'b0;
  end
endmodule

// File: rtl/keyseq_wdg_trip.sv
module keyseq_wdg_trip (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic bad_value,
  input  logic bad_order,
  input  logic early_key,
  input  logic at_end,
  input  logic svc_done,
  output logic trip,
  output logic rst_req
);
  logic expired;

  assign expired = at_end && !svc_done;
  assign trip    = active && (bad_value || bad_order || early_key || expired);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req <= 1'b0;
    else        rst_req <= trip;
  end
endmodule

// File: rtl/keyseq_watchdog.sv
module keyseq_watchdog #(
  parameter int BASE_LOG = 10
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wd_en,
  input  logic [keyseq_wdg_pkg::SEL_W-1:0] period_sel,
  input  logic                             window_en,
  input  logic                             svc_wr,
  input  logic [7:0]                       svc_data,
  output logic                             rst_req
);
  localparam int SEL_MAX = (1 << keyseq_wdg_pkg::SEL_W) - 1;
  localparam int CW      = BASE_LOG + 2 * SEL_MAX + 1;

  logic          active;
  logic          win_ok;
  logic          trip;
  logic          svc_done;
  logic          armed;
  logic          bad_value;
  logic          bad_order;
  logic          early_key;
  logic          at_end;
  logic          in_window;
  logic [CW-1:0] cnt;

  assign active = wd_en && (period_sel != '0);
  assign win_ok = !window_en || in_window;

  keyseq_wdg_counter #(.BASE_LOG(BASE_LOG), .CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .active(active), .restart(trip || svc_done),
    .sel(period_sel), .cnt(cnt), .at_end(at_end), .in_window(in_window)
  );

  keyseq_wdg_keytrack u_key (
    .clk(clk), .rst_n(rst_n), .active(active), .flush(trip),
    .svc_wr(svc_wr), .svc_data(svc_data), .win_ok(win_ok),
    .armed(armed), .svc_done(svc_done), .bad_value(bad_value),
    .bad_order(bad_order), .early_key(early_key)
  );

  keyseq_wdg_trip u_trip (
    .clk(clk), .rst_n(rst_n), .active(active), .bad_value(bad_value),
    .bad_order(bad_order), .early_key(early_key), .at_end(at_end),
    .svc_done(svc_done), .trip(trip), .rst_req(rst_req)
  );
endmodule

// File: rtl/keyseq_watchdog_chk.sv
module keyseq_watchdog_chk #(
  parameter int CW = 25
) (
  input logic          clk,
  input logic          rst_n,
  input logic          active,
  input logic          window_en,
  input logic          svc_wr,
  input logic [7:0]    svc_data,
  input logic          in_window,
  input logic          at_end,
  input logic          svc_done,
  input logic          armed,
  input logic [CW-1:0] cnt,
  input logic          rst_req
);
  logic key_byte;
  assign key_byte = (svc_data == 8'h55) || (svc_data == 8'hAA);

  // R1
  service_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_done |=> (cnt == '0) && !rst_req);
  // R3
  illegal_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && svc_wr && !key_byte |=> rst_req);
  // R4
  timeout_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && at_end && !svc_wr |=> rst_req);
  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !rst_req && (cnt == '0));
  // R7
  early_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && window_en && svc_wr && key_byte && !in_window |=> rst_req);
  // R8
  unarmed_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && svc_wr && (svc_data == 8'hAA) && !armed |=> rst_req);
  // R10
  fault_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (cnt == '0) && !armed);
endmodule

bind keyseq_watchdog keyseq_watchdog_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .window_en(window_en),
  .svc_wr(svc_wr), .svc_data(svc_data), .in_window(in_window),
  .at_end(at_end), .svc_done(svc_done), .armed(armed), .cnt(cnt),
  .rst_req(rst_req)
);

// File: tb/keyseq_watchdog_tb.sv
module keyseq_watchdog_tb;
  localparam int BL = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wd_en;
  logic [2:0] period_sel;
  logic       window_en;
  logic       svc_wr;
  logic [7:0] svc_data;
  logic       rst_req;

  always #10 clk = ~clk;

  keyseq_watchdog #(.BASE_LOG(BL)) u_dut (
    .clk(clk), .rst_n(rst_n), .wd_en(wd_en), .period_sel(period_sel),
    .window_en(window_en), .svc_wr(svc_wr), .svc_data(svc_data),
    .rst_req(rst_req)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int at; string req; } exp_t;
  exp_t  exp_q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R4";
  bit    done = 1'b0;

  function automatic int period(input int sel);
    return 1 << (BL + 2 * sel);
  endfunction

  task automatic expect_at(input int at, input string req);
    exp_t x;
    x.at = at;
    x.req = req;
    exp_q.push_back(x);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: rst_req actual %b expected %b", req, act, exp);
    end
  endtask

  // monitor: compare pulses against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (exp_q.size() > 0 && exp_q[0].at < cyc) begin
        n_cmp++;
        n_bad++;
        $display("FAIL %s: no pulse at edge %0d (actual 0 expected 1)", exp_q[0].req, exp_q[0].at);
        void'(exp_q.pop_front());
      end
      if (rst_req === 1'b1) begin
        n_cmp++;
        if (exp_q.size() > 0 && exp_q[0].at == cyc) begin
          void'(exp_q.pop_front());
        end else begin
          n_bad++;
          $display("FAIL %s: pulse at edge %0d (actual 1 expected 0)", cur_req, cyc);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic svc(input logic [7:0] d, output int e);
    e = cyc + 1;
    svc_wr = 1'b1;
    svc_data = d;
    @(negedge clk);
    svc_wr = 1'b0;
  endtask

  task automatic svc_fault(input logic [7:0] d, input string req, output int e);
    expect_at(cyc + 1, req);
    svc(d, e);
  endtask

  task automatic start(input int sel, input bit win, output int r);
    period_sel = sel[2:0];
    window_en = win;
    wd_en = 1'b1;
    r = cyc;
  endtask

  task automatic stop();
    wd_en = 1'b0;
    window_en = 1'b0;
    idle(3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run hung (actual running expected finished)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int r;
    int e;
    rst_n = 1'b0; wd_en = 1'b0; period_sel = 3'd0; window_en = 1'b0;
    svc_wr = 1'b0; svc_data = 8'h00;
    idle(4);
    chk("R4", rst_req, 1'b0);
    rst_n = 1'b1;
    idle(2);

    // R5: idle when disabled or select zero
    cur_req = "R5";
    period_sel = 3'd1;
    svc(8'h3C, e);
    idle(1);
    chk("R5", rst_req, 1'b0);
    period_sel = 3'd0; wd_en = 1'b1;
    svc(8'h3C, e);
    idle(1);
    chk("R5", rst_req, 1'b0);
    idle(300);
    stop();

    // R4 / R10: unserviced timeout repeats every period
    cur_req = "R4";
    start(1, 1'b0, r);
    expect_at(r + period(1), "R4");
    expect_at(r + 2 * period(1), "R10");
    idle(130);
    stop();

    // R1 / R2 / R9: services with gaps and a repeated arm byte
    cur_req = "R2";
    start(1, 1'b0, r);
    idle(20);
    svc(8'h55, e);
    idle(5);
    svc(8'hAA, e);
    cur_req = "R9";
    idle(30);
    svc(8'h55, e);
    svc(8'h55, e);
    idle(3);
    svc(8'hAA, e);
    cur_req = "R1";
    expect_at(e + period(1), "R1");
    idle(70);
    stop();

    // R3 / R10: illegal byte, then timeout one period later
    cur_req = "R3";
    start(1, 1'b0, r);
    idle(10);
    svc_fault(8'h3C, "R3", e);
    expect_at(e + period(1), "R10");
    idle(70);
    stop();

    // R8: fire byte without arm
    cur_req = "R8";
    start(1, 1'b0, r);
    idle(5);
    svc_fault(8'hAA, "R8", e);
    idle(3);
    stop();

    // R10: fault drops armed state
    cur_req = "R10";
    start(1, 1'b0, r);
    idle(3);
    svc(8'h55, e);
    svc_fault(8'h00, "R3", e);
    svc_fault(8'hAA, "R10", e);
    idle(3);
    stop();

    // R6 / R7: window boundaries at counts 47 and 48 (T = 64)
    cur_req = "R7";
    start(1, 1'b1, r);
    idle(9);
    svc_fault(8'h55, "R7", e);
    idle(48);
    cur_req = "R6";
    svc(8'h55, e);
    svc(8'hAA, e);
    cur_req = "R7";
    idle(47);
    svc_fault(8'h55, "R7", e);
    idle(48);
    cur_req = "R6";
    svc(8'h55, e);
    svc(8'hAA, e);
    expect_at(e + period(1), "R6");
    idle(70);
    stop();

    // R5: longer periods from the select
    cur_req = "R5";
    start(2, 1'b0, r);
    expect_at(r + period(2), "R5");
    expect_at(r + 2 * period(2), "R5");
    idle(515);
    stop();
    start(3, 1'b0, r);
    expect_at(r + period(3), "R5");
    idle(1030);
    stop();

    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL %s: %0d pulses outstanding (expected 0)", exp_q[0].req, exp_q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule